// File: doc/BRIEF.md
# Interleaved Shared RAM Controller

This controller lets a processor and a display fetch engine share a single RAM with no contention and no arbiter. The controller and the RAM run on a clock at twice the processor rate. A phase bit, aligned to the processor clock, splits that fast clock into alternating slots. In the even slot the RAM is addressed by the processor, and in the odd slot it is addressed by the display engine. Each side gets a fixed, guaranteed access every processor cycle, so neither side ever stalls.

On the processor side, the controller decodes a RAM window in the processor's 16-bit address space. The window starts at `BASE` and spans `NUM_PAGES` pages of `2**PAGE_BITS` bytes each. A control register holds one write-protect bit per page. In the target configuration (`PAGE_BITS=12`), the window is five 4 kB pages at 0x8000–0xCFFF. A loader fills the interpreter pages at 0xA000–0xBFFF and then protects them. The defaults are scaled to 256-byte pages so that the memory stays small: the window is 0x8000–0x84FF, and the protect register is at 0xD000. Writes to a protected page are dropped without any error indication. Reads from a protected page, by either side, still return the stored data.

Top module: `shmem_ctrl`

## Requirements
- R1: `cpu_slot` is 1 while reset is held and in the first clock after reset is released. It then inverts on every clock. A slot with `cpu_slot`=1 is a processor (even) slot, and a slot with `cpu_slot`=0 is a display (odd) slot.
- R2: A processor write at an address inside the window, during an even slot, stores `cpu_wdata`. A later read at the same address returns that value on `cpu_rdata` one clock after its even slot. The value is held until the next even slot ends.
- R3: The display engine presents a RAM index (address minus `BASE`) on `vid_addr` during an odd slot. `vid_rdata` shows that byte one clock later and does not change during the following even slot.
- R4: A processor write and a display read in the same processor cycle both complete. A display read of the index just written by the processor returns the new value.
- R5: Processor accesses below `BASE`, or at or above `BASE + NUM_PAGES*2**PAGE_BITS`, do not touch the RAM. Reads there return 0 unless the address is the protect register.
- R6: The protect register sits at `WP_ADDR`, and bit i protects page i, where page 0 starts at `BASE`. A read returns the register value zero-extended to the data width. Writes keep only the low `NUM_PAGES` bits, and the register changes only at the end of an even slot.
- R7: A write to a page whose protect bit is 1 leaves memory unchanged. Reads of that page, on either side, return the stored data. Pages whose protect bit is 0 stay writable.
- R8: A display index at or beyond the window size returns 0 on `vid_rdata`.
- R9: Reset clears the protect register, `cpu_rdata` and `vid_rdata` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RAM clock, twice the processor rate |
| rst | input | 1 | Synchronous active-high reset |
| cpu_slot | output | 1 | 1 during the processor (even) slot |
| cpu_addr | input | ADDR_W | Processor byte address |
| cpu_we | input | 1 | Processor write strobe, sampled in the even slot |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_rdata | output | DATA_W | Processor read data, RAM or protect register |
| vid_addr | input | IDX_W | Display RAM index, sampled in the odd slot |
| vid_rdata | output | DATA_W | Display read data |

## Verification
The assertions take two things for granted about the inputs. The processor keeps its address, strobe and data steady through each even slot. The display engine's index is only meaningful in odd slots. The properties therefore constrain outputs and internal enables only at slot boundaries. The bench drives processor inputs on the falling edge that opens an even slot and clears the write strobe in the following odd slot. It drives display indices on the falling edge that opens an odd slot, so every sample lands in a slot where the relevant side owns the RAM.

// File: rtl/shmem_pkg.sv
package shmem_pkg;
  // Result of decoding one processor address
  typedef struct packed {
    logic ram;   // inside the RAM window
    logic ctl;   // protect register
  } cpu_hit_t;
endpackage

// File: rtl/shmem_slot_phase.sv
module shmem_slot_phase (
  input  logic clk,
  input  logic rst,
  output logic even_slot
);
  always_ff @(posedge clk) begin
    if (rst) even_slot <= 1'b1;
    else     even_slot <= ~even_slot;
  end
endmodule

// File: rtl/shmem_cpu_decode.sv
module shmem_cpu_decode #(
  parameter int ADDR_W    = 16,
  parameter int BASE      = 'h8000,
  parameter int PAGE_BITS = 8,
  parameter int NUM_PAGES = 5,
  parameter int WP_ADDR   = 'hD000,
  localparam int DEPTH    = NUM_PAGES << PAGE_BITS,
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int PG_W     = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
  input  logic [ADDR_W-1:0]  addr,
  output shmem_pkg::cpu_hit_t hit,
  output logic [IDX_W-1:0]   idx,
  output logic [PG_W-1:0]    page
);
  localparam logic [ADDR_W-1:0] BASE_V  = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] DEPTH_V = ADDR_W'(DEPTH);
  localparam logic [ADDR_W-1:0] CTL_V   = ADDR_W'(WP_ADDR);

  logic [ADDR_W-1:0] offset;

  always_comb begin
    offset  = addr - BASE_V;
    hit.ram = (addr >= BASE_V) && (offset < DEPTH_V);
    hit.ctl = (addr == CTL_V);
    idx     = IDX_W'(offset);
    page    = PG_W'(offset >> PAGE_BITS);
  end
endmodule

// File: rtl/shmem_wprot.sv
module shmem_wprot #(
  parameter int NUM_PAGES = 5,
  localparam int PG_W     = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [NUM_PAGES-1:0] load_val,
  input  logic [PG_W-1:0]      page,
  output logic [NUM_PAGES-1:0] bits,
  output logic                 locked
);
  always_ff @(posedge clk) begin
    if (rst)       bits <= '0;
    else if (load) bits <= load_val;
  end

  // Bit lookup that stays in range for any page code
  always_comb begin
    locked = 1'b0;
    for (int i = 0; i < NUM_PAGES; i++) begin
      if (page == PG_W'(i)) locked = bits[i];
    end
  end
endmodule

// File: rtl/shmem_ram.sv
module shmem_ram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 1280,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              vid_sel,
  output logic [DATA_W-1:0] q_cpu,
  output logic [DATA_W-1:0] q_vid
);
  localparam logic [IDX_W:0] DEPTH_V = (IDX_W+1)'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic              in_range;

  assign in_range = ({1'b0, addr} < DEPTH_V);

  // Single port, read-first; write strobe only in range
  always_ff @(posedge clk) begin
    if (we && in_range) mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_cpu <= '0;
      q_vid <= '0;
    end else if (vid_sel) begin
      q_vid <= in_range ? mem[addr] : '0;
    end else begin
      q_cpu <= in_range ? mem[addr] : '0;
    end
  end
endmodule

// File: rtl/shmem_ctrl.sv
module shmem_ctrl #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int BASE      = 'h8000,
  parameter int PAGE_BITS = 8,
  parameter int NUM_PAGES = 5,
  parameter int WP_ADDR   = 'hD000,
  localparam int DEPTH    = NUM_PAGES << PAGE_BITS,
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int PG_W     = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  output logic              cpu_slot,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_we,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic [IDX_W-1:0]  vid_addr,
  output logic [DATA_W-1:0] vid_rdata
);
  import shmem_pkg::*;

  cpu_hit_t              hit;
  logic [IDX_W-1:0]      cpu_idx;
  logic [PG_W-1:0]       cpu_page;
  logic [NUM_PAGES-1:0]  wp_bits;
  logic                  prot_hit;
  logic                  ram_we;
  logic                  wp_load;
  logic [IDX_W-1:0]      ram_addr;
  logic [DATA_W-1:0]     q_cpu;
  logic                  sel_ram_q;
  logic                  sel_ctl_q;
  logic [NUM_PAGES-1:0]  wp_snap;

  shmem_slot_phase u_phase (
    .clk       (clk),
    .rst       (rst),
    .even_slot (cpu_slot)
  );

  shmem_cpu_decode #(
    .ADDR_W    (ADDR_W),
    .BASE      (BASE),
    .PAGE_BITS (PAGE_BITS),
    .NUM_PAGES (NUM_PAGES),
    .WP_ADDR   (WP_ADDR)
  ) u_dec (
    .addr (cpu_addr),
    .hit  (hit),
    .idx  (cpu_idx),
    .page (cpu_page)
  );

  assign wp_load = cpu_slot & cpu_we & hit.ctl;

  shmem_wprot #(.NUM_PAGES(NUM_PAGES)) u_wp (
    .clk      (clk),
    .rst      (rst),
    .load     (wp_load),
    .load_val (cpu_wdata[NUM_PAGES-1:0]),
    .page     (cpu_page),
    .bits     (wp_bits),
    .locked   (prot_hit)
  );

  // Slot steering: even slot to the processor, odd slot to the display
  assign ram_addr = cpu_slot ? cpu_idx : vid_addr;
  assign ram_we   = cpu_slot & cpu_we & hit.ram & ~prot_hit;

  shmem_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk     (clk),
    .rst     (rst),
    .addr    (ram_addr),
    .we      (ram_we),
    .wdata   (cpu_wdata),
    .vid_sel (~cpu_slot),
    .q_cpu   (q_cpu),
    .q_vid   (vid_rdata)
  );

  // Source select for processor read data, captured with the RAM output
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_ram_q <= 1'b0;
      sel_ctl_q <= 1'b0;
      wp_snap   <= '0;
    end else if (cpu_slot) begin
      sel_ram_q <= hit.ram;
      sel_ctl_q <= hit.ctl;
      wp_snap   <= wp_bits;
    end
  end

  always_comb begin
    if (sel_ram_q)      cpu_rdata = q_cpu;
    else if (sel_ctl_q) cpu_rdata = DATA_W'(wp_snap);
    else                cpu_rdata = '0;
  end
endmodule

// File: rtl/shmem_ctrl_chk.sv
module shmem_ctrl_chk #(
  parameter int DATA_W    = 8,
  parameter int NUM_PAGES = 5
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cpu_slot,
  input logic [DATA_W-1:0]    cpu_rdata,
  input logic [DATA_W-1:0]    vid_rdata,
  input logic [NUM_PAGES-1:0] wp_bits,
  input logic                 ram_we,
  input logic                 prot_hit,
  input logic                 hit_ram
);
  assert_slot_alternate_R1: assert property (@(posedge clk) disable iff (rst)
    cpu_slot |=> !cpu_slot);
  assert_slot_return_R1: assert property (@(posedge clk) disable iff (rst)
    !cpu_slot |=> cpu_slot);
  assert_cpu_data_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !cpu_slot |=> $stable(cpu_rdata));
  assert_vid_data_hold_R3: assert property (@(posedge clk) disable iff (rst)
    cpu_slot |=> $stable(vid_rdata));
  assert_write_in_window_R5: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (hit_ram && cpu_slot));
  assert_wp_only_even_R6: assert property (@(posedge clk) disable iff (rst)
    !cpu_slot |=> $stable(wp_bits));
  assert_prot_block_R7: assert property (@(posedge clk) disable iff (rst)
    prot_hit |-> !ram_we);
  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> (wp_bits == '0 && cpu_rdata == '0 && vid_rdata == '0));
endmodule

bind shmem_ctrl shmem_ctrl_chk #(.DATA_W(DATA_W), .NUM_PAGES(NUM_PAGES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cpu_slot  (cpu_slot),
  .cpu_rdata (cpu_rdata),
  .vid_rdata (vid_rdata),
  .wp_bits   (wp_bits),
  .ram_we    (ram_we),
  .prot_hit  (prot_hit),
  .hit_ram   (hit.ram)
);

// File: tb/sim_shmem_ctrl.sv
`timescale 1ns/1ps
module sim_shmem_ctrl;
  localparam int IDX_W = 11;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_slot;
  logic [15:0] cpu_addr = '0;
  logic        cpu_we = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic [IDX_W-1:0] vid_addr = '0;
  logic [7:0]  vid_rdata;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  shmem_ctrl u0 (
    .clk(clk), .rst(rst), .cpu_slot(cpu_slot),
    .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .vid_addr(vid_addr), .vid_rdata(vid_rdata)
  );

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic to_even();
    @(negedge clk);
    while (!cpu_slot) @(negedge clk);
  endtask

  task automatic to_odd();
    @(negedge clk);
    while (cpu_slot) @(negedge clk);
  endtask

  task automatic cpu_wr(input logic [15:0] a, input logic [7:0] d);
    to_even();
    cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic cpu_rd(input logic [15:0] a, output logic [7:0] d);
    to_even();
    cpu_addr = a; cpu_we = 1'b0;
    @(negedge clk);
    d = cpu_rdata;
  endtask

  task automatic vid_rd(input logic [IDX_W-1:0] i, output logic [7:0] d);
    to_odd();
    vid_addr = i;
    @(negedge clk);
    d = vid_rdata;
  endtask

  task automatic t_reset();
    check("R9 cpu_rdata after reset", cpu_rdata, 0);
    check("R9 vid_rdata after reset", vid_rdata, 0);
    check("R1 slot at release", cpu_slot, 1);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check("R1 slot alternation", cpu_slot, (k % 2 == 0) ? 0 : 1);
    end
  endtask

  task automatic t_cpu_rw();
    logic [7:0] d;
    cpu_rd(16'hD000, d); check("R6 reset value of protect reg", d, 0);
    cpu_wr(16'h8000, 8'hA5);
    cpu_wr(16'h80FF, 8'h3C);
    cpu_wr(16'h84FF, 8'h5A);
    cpu_rd(16'h8000, d); check("R2 read first byte", d, 8'hA5);
    cpu_rd(16'h80FF, d); check("R2 read page end", d, 8'h3C);
    cpu_rd(16'h84FF, d); check("R2 read last byte", d, 8'h5A);
    @(negedge clk);
    check("R2 data held in odd slot", cpu_rdata, 8'h5A);
  endtask

  task automatic t_video();
    logic [7:0] d;
    vid_rd(11'h000, d); check("R3 video index 0", d, 8'hA5);
    vid_rd(11'h4FF, d); check("R3 video last index", d, 8'h5A);
    vid_addr = 11'h0FF;
    @(negedge clk);
    check("R3 video held in even slot", vid_rdata, 8'h5A);
    @(negedge clk);
    check("R3 video updates after odd slot", vid_rdata, 8'h3C);
  endtask

  task automatic t_concurrent();
    to_even();
    cpu_addr = 16'h8123; cpu_wdata = 8'h96; cpu_we = 1'b1;
    vid_addr = 11'h123;
    @(negedge clk);
    cpu_we = 1'b0;
    @(negedge clk);
    check("R4 video sees same-cycle write", vid_rdata, 8'h96);
    to_even();
    cpu_addr = 16'h8124; cpu_wdata = 8'h69; cpu_we = 1'b1;
    vid_addr = 11'h0FF;
    @(negedge clk);
    cpu_we = 1'b0;
    @(negedge clk);
    check("R4 video other index during write", vid_rdata, 8'h3C);
  endtask

  task automatic t_window();
    logic [7:0] d;
    cpu_wr(16'h7FFF, 8'hEE);
    cpu_wr(16'h8500, 8'hDD);
    cpu_rd(16'h7FFF, d); check("R5 read below window", d, 0);
    cpu_rd(16'h8500, d); check("R5 read above window", d, 0);
    vid_rd(11'h000, d); check("R5 no alias write at index 0", d, 8'hA5);
    vid_rd(11'h4FF, d); check("R5 last byte untouched", d, 8'h5A);
  endtask

  task automatic t_protect();
    logic [7:0] d;
    cpu_wr(16'h8200, 8'h11);
    cpu_wr(16'hD000, 8'hFF);
    cpu_rd(16'hD000, d); check("R6 only low bits kept", d, 8'h1F);
    cpu_wr(16'hD000, 8'h0C);
    cpu_rd(16'hD000, d); check("R6 readback", d, 8'h0C);
    cpu_wr(16'h8200, 8'hEE);
    cpu_rd(16'h8200, d); check("R7 protected write dropped", d, 8'h11);
    vid_rd(11'h200, d); check("R7 video reads protected page", d, 8'h11);
    cpu_wr(16'h83FF, 8'hEE);
    vid_rd(11'h3FF, d); check("R7 page 3 end protected", d, 0);
    cpu_wr(16'h8100, 8'h77);
    cpu_rd(16'h8100, d); check("R7 unprotected page writable", d, 8'h77);
    cpu_wr(16'h8400, 8'h44);
    cpu_rd(16'h8400, d); check("R7 page 4 writable", d, 8'h44);
    cpu_wr(16'hD000, 8'h00);
    cpu_wr(16'h8200, 8'hEE);
    cpu_rd(16'h8200, d); check("R7 writable after unprotect", d, 8'hEE);
  endtask

  task automatic t_vid_range();
    logic [7:0] d;
    vid_rd(11'h500, d); check("R8 video index past window", d, 0);
    vid_rd(11'h7FF, d); check("R8 video top index", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // 0x83FF was never written; clear it so the R7 check has a known value
    rst = 1'b0;
    t_reset();
    cpu_wr(16'h83FF, 8'h00);
    t_cpu_rw();
    t_video();
    t_concurrent();
    t_window();
    t_protect();
    t_vid_range();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule